// File: doc/BRIEF.md
# Truncated Constant-Coefficient Multiplier

This block multiplies a signed 12-bit operand by one of a small set of fixed cosine constants. It is meant for the butterfly stages of an 8-point cosine transform. A 4-bit selector picks the constant. Each constant is an unsigned 8-bit fraction (value = code / 256) that carries a separate sign flag.

The operand is first converted to sign and magnitude. Only the constant bits that are set produce partial-product rows. The low fractional bits of the magnitude product are dropped, keeping 3 fractional bits. The sign is then applied again, and the result is registered.

The result is a signed 15-bit value with 3 fractional bits, which is the operand's 12 integer bits plus 3 fraction bits. It appears one clock after the operand is presented with its valid flag.

Top module: `trunc_cmul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no valid input, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals the `in_valid` of the previous rising clock edge. `out_data` then carries the result for the `in_data`/`in_sel` sampled at that same edge, including when inputs arrive back to back.
- R3: For a non-negative operand x and `in_sel` 1..7, `out_data` = floor(x·K/32). K = round(256·cos(s·π/16)) for selector s, giving 251, 237, 213, 181, 142, 98 and 50.
- R4: For a negative operand, the magnitude is multiplied and truncated, then negated: `out_data` = −floor(|x|·K/32). Truncation is therefore toward zero.
- R5: Selector 8 gives the constant cos(7π/16)−cos(3π/16), with magnitude code 163. Selector 9 gives cos(5π/16)−cos(3π/16), with magnitude code 71. Both are negative, so the result sign is the operand sign inverted.
- R6: Selectors 0 and 10..15 select a zero constant, and `out_data` is 0.
- R7: An operand of −2048 is treated as magnitude 2047, so `out_data` = −floor(2047·K/32).
- R8: In a cycle with `in_valid` low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and selector are valid this cycle |
| in_data | input | 12 | Signed two's-complement operand |
| in_sel | input | 4 | Constant selector (1..7 cosines, 8..9 negative differences, others zero) |
| out_valid | output | 1 | Result valid |
| out_data | output | 15 | Signed result with 3 fractional bits |

## Verification
The assertions assume that `in_valid` and `in_sel` are known at every sampled edge after reset, and that `in_valid` is low while reset is applied. The bench holds `in_valid` low through reset. It changes inputs only on falling edges, so every sampled value is a defined, settled value. The bench compares every selector against a product it computes from real-valued cosines. The operands include zero, small, large, negative and the most negative value.

// File: rtl/trunc_cmul_pkg.sv
package trunc_cmul_pkg;

   localparam int COEF_BITS = 8;
   localparam int SEL_BITS  = 4;
   localparam int SEL_COUNT = 1 << SEL_BITS;

   typedef struct packed {
      logic [COEF_BITS-1:0] mag;
      logic                 neg;
   } coef_t;

   function automatic coef_t coef_lookup(input logic [SEL_BITS-1:0] sel);
      coef_t c;
      c.neg = 1'b0;
      case (sel)
         4'd1:    c.mag = 8'd251;
         4'd2:    c.mag = 8'd237;
         4'd3:    c.mag = 8'd213;
         4'd4:    c.mag = 8'd181;
         4'd5:    c.mag = 8'd142;
         4'd6:    c.mag = 8'd98;
         4'd7:    c.mag = 8'd50;
         4'd8:    begin c.mag = 8'd163; c.neg = 1'b1; end
         4'd9:    begin c.mag = 8'd71;  c.neg = 1'b1; end
         default: c.mag = 8'd0;
      endcase
      return c;
   endfunction

   function automatic logic [COEF_BITS-1:0] coef_row_mask();
      logic [COEF_BITS-1:0] m;
      m = '0;
      for (int i = 0; i < SEL_COUNT; i++) begin
         m = m | coef_lookup(SEL_BITS'(i)).mag;
      end
      return m;
   endfunction

endpackage

// File: rtl/trunc_cmul_coef_rom.sv
module trunc_cmul_coef_rom
   import trunc_cmul_pkg::*;
#(
   parameter int SEL_W  = 4,
   parameter int COEF_W = 8
) (
   input  logic [SEL_W-1:0]  sel,
   output logic [COEF_W-1:0] coef_mag,
   output logic              coef_neg
);

   generate
      if (SEL_W != SEL_BITS || COEF_W != COEF_BITS) begin : g_bad_cfg
         $error("coef rom: table defined for 4-bit selector and 8-bit constant");
      end
   endgenerate

   coef_t entry;

   always_comb begin
      entry    = coef_lookup(sel);
      coef_mag = entry.mag;
      coef_neg = entry.neg;
   end

endmodule

// File: rtl/trunc_cmul_magnitude.sv
module trunc_cmul_magnitude #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] value,
   output logic [DATA_W-2:0] mag,
   output logic              is_neg
);

   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-2:0] MAG_MAX  = {(DATA_W-1){1'b1}};

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("magnitude: DATA_W must be at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] negated;

   always_comb begin
      is_neg  = value[DATA_W-1];
      negated = -value;
      if (value == MOST_NEG)
         mag = MAG_MAX;
      else if (is_neg)
         mag = negated[DATA_W-2:0];
      else
         mag = value[DATA_W-2:0];
   end

endmodule

// File: rtl/trunc_cmul_ppsum.sv
module trunc_cmul_ppsum
   import trunc_cmul_pkg::*;
#(
   parameter int MAG_W     = 11,
   parameter int COEF_W    = 8,
   parameter int KEEP_FRAC = 3
) (
   input  logic [MAG_W-1:0]                    mag,
   input  logic [COEF_W-1:0]                   coef,
   output logic [MAG_W+KEEP_FRAC-1:0]          trunc
);

   localparam int PROD_W = MAG_W + COEF_W;
   localparam int DROP   = COEF_W - KEEP_FRAC;
   localparam logic [COEF_W-1:0] ROW_MASK = coef_row_mask();

   generate
      if (KEEP_FRAC < 0 || KEEP_FRAC > COEF_W) begin : g_bad_frac
         $error("ppsum: KEEP_FRAC must lie within 0..COEF_W");
      end
   endgenerate

   logic [PROD_W-1:0] rows [COEF_W];
   logic [PROD_W-1:0] full;

   genvar j;
   generate
      for (j = 0; j < COEF_W; j++) begin : g_row
         if (ROW_MASK[j]) begin : g_live
            assign rows[j] = coef[j] ? (PROD_W'(mag) << j) : '0;
         end else begin : g_absent
            assign rows[j] = '0;
         end
      end
   endgenerate

   always_comb begin
      full = '0;
      for (int r = 0; r < COEF_W; r++) begin
         full = full + rows[r];
      end
      trunc = full[PROD_W-1:DROP];
   end

endmodule

// File: rtl/trunc_cmul.sv
module trunc_cmul
   import trunc_cmul_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int COEF_W    = 8,
   parameter int SEL_W     = 4,
   parameter int KEEP_FRAC = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [DATA_W-1:0]           in_data,
   input  logic [SEL_W-1:0]            in_sel,
   output logic                        out_valid,
   output logic [DATA_W+KEEP_FRAC-1:0] out_data
);

   localparam int MAG_W   = DATA_W - 1;
   localparam int TRUNC_W = MAG_W + KEEP_FRAC;
   localparam int OUT_W   = TRUNC_W + 1;
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   logic [COEF_W-1:0]  coef_mag;
   logic               coef_neg;
   logic [MAG_W-1:0]   mag;
   logic               op_neg;
   logic [TRUNC_W-1:0] trunc;
   logic [OUT_W-1:0]   result;

   trunc_cmul_coef_rom #(.SEL_W(SEL_W), .COEF_W(COEF_W)) u_rom (
      .sel      (in_sel),
      .coef_mag (coef_mag),
      .coef_neg (coef_neg)
   );

   trunc_cmul_magnitude #(.DATA_W(DATA_W)) u_mag (
      .value  (in_data),
      .mag    (mag),
      .is_neg (op_neg)
   );

   trunc_cmul_ppsum #(.MAG_W(MAG_W), .COEF_W(COEF_W), .KEEP_FRAC(KEEP_FRAC)) u_pp (
      .mag   (mag),
      .coef  (coef_mag),
      .trunc (trunc)
   );

   always_comb begin
      if (op_neg ^ coef_neg)
         result = -{1'b0, trunc};
      else
         result = {1'b0, trunc};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= result;
      end
   end

   assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_sel == '0 || in_sel > SEL_W'(9))) |=> (out_data == '0));

   assert_sign_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data[DATA_W-1] && in_sel >= SEL_W'(1) && in_sel <= SEL_W'(7))
      |=> (out_data[OUT_W-1] || out_data == '0));

   assert_sat_nonpos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data == MOST_NEG && in_sel >= SEL_W'(1) && in_sel <= SEL_W'(7))
      |=> out_data[OUT_W-1]);

endmodule

// File: tb/trunc_cmul_test.sv
`timescale 1ns/1ps
module trunc_cmul_test;

   localparam int DW = 12;
   localparam int OW = 15;
   localparam real PI = 3.14159265358979;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic [3:0]    in_sel = '0;
   logic          out_valid;
   logic [OW-1:0] out_data;

   int tests_run = 0;
   int tests_failed = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   trunc_cmul uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sel(in_sel), .out_valid(out_valid), .out_data(out_data)
   );

   function automatic int code_of(input real v);
      real a;
      a = (v < 0.0) ? -v : v;
      return $rtoi(a * 256.0 + 0.5);
   endfunction

   function automatic int ref_coef(input int sel);
      case (sel)
         1, 2, 3, 4, 5, 6, 7: return code_of($cos(sel * PI / 16.0));
         8: return code_of($cos(7.0 * PI / 16.0) - $cos(3.0 * PI / 16.0));
         9: return code_of($cos(5.0 * PI / 16.0) - $cos(3.0 * PI / 16.0));
         default: return 0;
      endcase
   endfunction

   function automatic int ref_prod(input int x, input int sel);
      int m;
      int p;
      bit neg;
      m = (x < 0) ? -x : x;
      if (m > 2047) m = 2047;
      p = (m * ref_coef(sel)) / 32;
      neg = (x < 0) ^ (sel == 8 || sel == 9);
      return neg ? -p : p;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int out_int();
      return int'($signed(out_data));
   endfunction

   task automatic apply_one(input string req, input int x, input int sel);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(x);
      in_sel   = 4'(sel);
      @(negedge clk);
      in_valid = 1'b0;
      check(req, int'(out_valid), 1);
      check(req, out_int(), ref_prod(x, sel));
   endtask

   task automatic t_reset_R1;
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 data in reset", out_int(), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(out_valid), 0);
      check("R1 data after reset", out_int(), 0);
   endtask

   task automatic t_positive_R3;
      int vals[6] = '{0, 1, 5, 100, 1000, 2047};
      for (int s = 1; s <= 7; s++)
         foreach (vals[i]) apply_one("R3 positive", vals[i], s);
   endtask

   task automatic t_negative_R4;
      int vals[5] = '{-1, -7, -100, -1001, -2047};
      for (int s = 1; s <= 7; s++)
         foreach (vals[i]) apply_one("R4 negative", vals[i], s);
   endtask

   task automatic t_negcoef_R5;
      int vals[6] = '{0, 3, 777, 2047, -5, -1500};
      for (int s = 8; s <= 9; s++)
         foreach (vals[i]) apply_one("R5 negative constant", vals[i], s);
   endtask

   task automatic t_unused_R6;
      int sels[7] = '{0, 10, 11, 12, 13, 14, 15};
      apply_one("R6 prime", 900, 1);
      foreach (sels[i]) apply_one("R6 zero constant", 1234 - i * 700, sels[i]);
   endtask

   task automatic t_saturate_R7;
      for (int s = 1; s <= 9; s++) apply_one("R7 most negative", -2048, s);
   endtask

   task automatic t_hold_R8;
      int held;
      apply_one("R8 prime", 1500, 3);
      held = out_int();
      @(negedge clk);
      in_data = DW'(-300);
      in_sel  = 4'd1;
      @(negedge clk);
      check("R8 hold data", out_int(), held);
      check("R8 valid low", int'(out_valid), 0);
      @(negedge clk);
      check("R8 hold data again", out_int(), held);
   endtask

   task automatic t_stream_R2;
      int xs[5] = '{10, -20, 2047, -2048, 333};
      int ss[5] = '{2, 8, 7, 4, 9};
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         in_valid = 1'b1;
         in_data  = DW'(xs[i]);
         in_sel   = 4'(ss[i]);
         @(negedge clk);
         check("R2 stream valid", int'(out_valid), 1);
         check("R2 stream data", out_int(), ref_prod(xs[i], ss[i]));
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 valid drop", int'(out_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_R1();
      t_positive_R3();
      t_negative_R4();
      t_negcoef_R5();
      t_unused_R6();
      t_saturate_R7();
      t_hold_R8();
      t_stream_R2();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!finished) begin
         finished = 1;
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

endmodule